// File: doc/BRIEF.md
# Down-Counting PWM Channel with Match Compare

This block is one channel of a pulse-width timer. A counter is loaded from a period value and counts down by one on every enabled clock. When it is 0 it reloads on the next enabled clock, which gives a period of period value plus one enabled clocks. A registered output is high while the count is above the active compare value. The high time in each period is therefore the period value minus the compare value, and the output falls when the count reaches the compare point.

Two control inputs shape the behaviour. The first decides what happens when the compare value equals the period value: the output either stays low for the whole period or stays high for the whole period. The second decides when a new compare value takes effect: on the next clock, or only at the next reload, so that a period already under way keeps its pulse width. A one-clock time-out pulse marks every reload.

Top module: `pwm_match_timer`

## Requirements
- R1: A synchronous active-high reset drives `pwm_out` and `timeout_out` low and clears the count to 0. The first enabled clock after reset therefore reloads the count and raises `timeout_out`.
- R2: Each enabled clock decrements a nonzero count by 1. An enabled clock at count 0 reloads the period value, and one clock later `timeout_out` is high for exactly one clock. Consecutive time-out pulses are period value + 1 enabled clocks apart.
- R3: When the compare value is below the period value, `pwm_out` is high for exactly (period − compare) clocks in each period. Compare = period − 1 gives 1 clock, compare = period − 2 gives 2 clocks, and compare = 0 gives a number of clocks equal to the period value.
- R4: When the compare value equals the period value and `eq_hold_low` = 1, `pwm_out` stays low for the whole period.
- R5: When the compare value equals the period value and `eq_hold_low` = 0, `pwm_out` stays high for the whole period (period + 1 clocks).
- R6: When the compare value is greater than the period value, `pwm_out` stays low in both settings of `eq_hold_low`.
- R7: With `defer_upd` = 1, a change on `match_val` is captured into the active compare register only on an enabled reload clock. A period already under way keeps its old pulse width.
- R8: With `defer_upd` = 0, the active compare register takes `match_val` on the next clock.
- R9: While `en` = 0, the count and `pwm_out` hold their values and `timeout_out` is low. On re-enable, counting resumes from the held count.
- R10: `load_val` is sampled only on a reload clock, so a change during a period does not alter the length of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| load_val | input | CNT_W | Period value, taken at reload |
| match_val | input | CNT_W | Compare value |
| eq_hold_low | input | 1 | 1: compare equal to period keeps the output low; 0: keeps it high |
| defer_upd | input | 1 | 1: compare value taken only at reload |
| pwm_out | output | 1 | Registered pulse-width output |
| timeout_out | output | 1 | One-clock pulse after each reload |

## Verification
The hardest case to reach from the ports is a compare change in the middle of a period. Telling deferred capture from immediate capture depends on the exact clock at which `match_val` moves relative to the reload. The bench locks onto the time-out pulse, counts clocks from it, and changes the compare value four clocks into a period. With deferred capture it expects the old pulse width for that period (6 clocks), and with immediate capture a truncated one (4 clocks). It then checks that the following period uses the new width. Changes to the period value and pauses of the enable are timed from the time-out pulse in the same way.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef struct packed {
    logic eq_low;   // equal-compare policy: 1 = low, 0 = high
    logic defer;    // compare update only at reload
  } pmc_ctrl_t;

  // Output level for one count value against the active compare and period.
  function automatic logic pmc_level(input logic [63:0] cnt,
                                     input logic [63:0] cmp,
                                     input logic [63:0] per,
                                     input logic        eq_low);
    if (cmp == per) return !eq_low;
    return (cnt > cmp);
  endfunction

endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] period,
  output logic             reload,
  output logic             tick
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, per_q;
  logic             tick_q;

  assign reload = en && (cnt_q == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= ZERO;
      per_q  <= ZERO;
      tick_q <= 1'b0;
    end else begin
      tick_q <= reload;
      if (reload) begin
        cnt_q <= load_val;
        per_q <= load_val;
      end else if (en) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign cnt    = cnt_q;
  assign period = per_q;
  assign tick   = tick_q;
endmodule

// File: rtl/pmc_match_reg.sv
module pmc_match_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             defer,
  input  logic             reload,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] match_act
);
  logic [CNT_W-1:0] act_q;
  logic             take;

  assign take = !defer || reload;

  always_ff @(posedge clk) begin
    if (rst)       act_q <= '0;
    else if (take) act_q <= match_val;
  end

  assign match_act = act_q;
endmodule

// File: rtl/pmc_compare.sv
module pmc_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             eq_low,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] match_act,
  input  logic [CNT_W-1:0] period,
  output logic             pwm
);
  import pmc_pkg::*;

  logic pwm_q, lvl;

  always_comb lvl = pmc_level(64'(cnt), 64'(match_act), 64'(period), eq_low);

  always_ff @(posedge clk) begin
    if (rst)     pwm_q <= 1'b0;
    else if (en) pwm_q <= lvl;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             eq_hold_low,
  input  logic             defer_upd,
  output logic             pwm_out,
  output logic             timeout_out
);
  import pmc_pkg::*;

  pmc_ctrl_t        ctrl;
  logic [CNT_W-1:0] cnt_q, period_q, match_q;
  logic             reload;

  assign ctrl.eq_low = eq_hold_low;
  assign ctrl.defer  = defer_upd;

  pmc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .load_val(load_val),
    .cnt(cnt_q), .period(period_q), .reload(reload), .tick(timeout_out)
  );

  pmc_match_reg #(.CNT_W(CNT_W)) u_mreg (
    .clk(clk), .rst(rst), .defer(ctrl.defer), .reload(reload),
    .match_val(match_val), .match_act(match_q)
  );

  pmc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .en(en), .eq_low(ctrl.eq_low),
    .cnt(cnt_q), .match_act(match_q), .period(period_q), .pwm(pwm_out)
  );
endmodule

// File: rtl/pwm_match_timer_chk.sv
module pwm_match_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] match_val,
  input logic             eq_hold_low,
  input logic             defer_upd,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] match_act,
  input logic             pwm_out,
  input logic             timeout_out
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!pwm_out && !timeout_out && cnt == '0));

  assert_reload_value_R2: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == '0) |=> (cnt == $past(load_val) && timeout_out));

  assert_countdown_R2: assert property (@(posedge clk) disable iff (rst)
    (en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1 && !timeout_out));

  assert_equal_low_R4: assert property (@(posedge clk) disable iff (rst)
    (en && eq_hold_low && match_act == period) |=> !pwm_out);

  assert_equal_high_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !eq_hold_low && match_act == period) |=> pwm_out);

  assert_above_period_R6: assert property (@(posedge clk) disable iff (rst)
    (en && match_act > period) |=> !pwm_out);

  assert_defer_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (defer_upd && !(en && cnt == '0)) |=> $stable(match_act));

  assert_immediate_take_R8: assert property (@(posedge clk) disable iff (rst)
    !defer_upd |=> (match_act == $past(match_val)));

  assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt) && $stable(pwm_out) && !timeout_out));

  assert_period_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !(en && cnt == '0) |=> $stable(period));
endmodule

bind pwm_match_timer pwm_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .load_val(load_val), .match_val(match_val),
  .eq_hold_low(eq_hold_low), .defer_upd(defer_upd), .cnt(cnt_q),
  .period(period_q), .match_act(match_q), .pwm_out(pwm_out),
  .timeout_out(timeout_out)
);

// File: tb/pwm_match_timer_bench.sv
module pwm_match_timer_bench;
  localparam int W = 16;
  localparam int NV = 10;
  // {period, compare, eq_hold_low, expected high clocks per period}
  localparam int VEC [NV][4] = '{
    '{9, 3, 1, 6}, '{9, 8, 1, 1}, '{9, 7, 1, 2}, '{9, 0, 1, 9},
    '{9, 9, 1, 0}, '{9, 9, 0, 10}, '{5, 12, 1, 0}, '{5, 12, 0, 0},
    '{1, 0, 1, 1}, '{0, 0, 0, 1}
  };

  logic clk = 0, rst = 1, en = 0, eq_hold_low = 1, defer_upd = 0;
  logic [W-1:0] load_val = '0, match_val = '0;
  logic pwm_out, timeout_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pwm_match_timer #(.CNT_W(W)) u_pwm_match_timer (
    .clk(clk), .rst(rst), .en(en), .load_val(load_val), .match_val(match_val),
    .eq_hold_low(eq_hold_low), .defer_upd(defer_upd),
    .pwm_out(pwm_out), .timeout_out(timeout_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance at least one clock, then stop on the first cycle with a time-out.
  task automatic next_timeout();
    int g = 0;
    @(negedge clk);
    while (!timeout_out && g < 1000) begin
      @(negedge clk);
      g++;
    end
  endtask

  // Count high clocks over one period starting at the current time-out cycle.
  task automatic window(input int per, output int highs);
    highs = 0;
    for (int i = 0; i <= per; i++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h, n;
    en = 1;
    repeat (3) @(negedge clk);
    check("R1 pwm at reset", int'(pwm_out), 0);
    check("R1 timeout at reset", int'(timeout_out), 0);
    rst = 0;
    @(negedge clk);
    check("R1 first enabled clock reloads", int'(timeout_out), 1);

    // Table of period/compare/policy vectors (R3..R6, period of R2)
    for (int v = 0; v < NV; v++) begin
      load_val = W'(VEC[v][0]);
      match_val = W'(VEC[v][1]);
      eq_hold_low = VEC[v][2][0];
      next_timeout();
      next_timeout();
      window(VEC[v][0], h);
      if (VEC[v][1] < VEC[v][0])       check($sformatf("R3 vec %0d width", v), h, VEC[v][3]);
      else if (VEC[v][1] > VEC[v][0])  check($sformatf("R6 vec %0d width", v), h, VEC[v][3]);
      else if (VEC[v][2] != 0)         check($sformatf("R4 vec %0d width", v), h, VEC[v][3]);
      else                             check($sformatf("R5 vec %0d width", v), h, VEC[v][3]);
      check($sformatf("R2 vec %0d period", v), int'(timeout_out), 1);
    end

    // R7 / R8: compare change four clocks into a period
    for (int d = 1; d >= 0; d--) begin
      load_val = 9; match_val = 3; eq_hold_low = 1; defer_upd = d[0];
      next_timeout();
      next_timeout();
      h = 0;
      for (int i = 0; i <= 9; i++) begin
        if (pwm_out) h++;
        if (i == 3) match_val = 7;
        @(negedge clk);
      end
      if (d == 1) check("R7 deferred change keeps width", h, 6);
      else        check("R8 immediate change truncates", h, 4);
      window(9, h);
      if (d == 1) check("R7 new width next period", h, 2);
      else        check("R8 new width next period", h, 2);
    end
    defer_upd = 0;

    // R10: period change mid-period
    load_val = 9; match_val = 3;
    next_timeout();
    next_timeout();
    n = 0;
    do begin
      if (n == 2) load_val = 4;
      @(negedge clk);
      n++;
    end while (!timeout_out && n < 100);
    check("R10 current period unchanged", n, 10);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!timeout_out && n < 100);
    check("R10 new period applied", n, 5);

    // R9: pause the enable
    load_val = 9;
    next_timeout();
    next_timeout();
    en = 0;
    @(negedge clk);
    h = int'(pwm_out);
    n = 0;
    for (int i = 0; i < 15; i++) begin
      if (timeout_out || int'(pwm_out) != h) n++;
      @(negedge clk);
    end
    check("R9 hold while disabled", n, 0);
    en = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!timeout_out && n < 100);
    check("R9 resume from held count", n, 10);

    // R1: reset in mid-run with output high
    match_val = 0;
    next_timeout();
    next_timeout();
    @(negedge clk);
    check("R1 output high before reset", int'(pwm_out), 1);
    rst = 1;
    @(negedge clk);
    check("R1 reset clears output", int'(pwm_out), 0);
    rst = 0;
    @(negedge clk);
    check("R1 reload after reset", int'(timeout_out), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule